// File: doc/BRIEF.md
# Masked-Address GPIO Port

An eight-pin general-purpose I/O port on a single-cycle register bus. Software sets each pin's direction, writes the values the pads drive, and reads the pin levels. The central feature is a data window that is repeated across the low kilobyte of the block's 4 KB address space. In that window, byte-address bits [9:2] form a per-pin select mask. A write through the window changes only the selected output bits. A read through the window returns only the selected pins and returns zero in every other bit. Software can therefore set or clear one pin with a single store and no read-modify-write, and it can test one pin by comparing the loaded word against zero.

The pad inputs pass through a two-flop synchroniser before they reach the read path. The block drives a per-pin output enable and output value toward the pads. The output value register keeps its contents while a pin is an input. Software can then preload the level a pin will drive before it turns that pin into an output.

Top module: `gpio_mask_port`

## Requirements
- R1: While `rst` is high, and after it falls, every pin is an input (`pad_oe` = 0), every output bit is 0 (`pad_out` = 0) and the direction register reads 0.
- R2: A write with `bus_sel` and `bus_we` high, at an aligned address below 0x400, loads `bus_wdata[n]` into output bit n for each pin n whose address bit n+2 is 1. An address whose bits [9:2] are all zero changes nothing.
- R3: In such a data write, output bits whose address bit n+2 is 0 keep their previous value.
- R4: A read at an aligned address below 0x400 returns 0 in every bit whose address bit n+2 is 0. A single-pin address returns that pin's level in bit n.
- R5: In a data read, a selected pin whose direction bit is 1 returns its output register bit. A selected pin whose direction bit is 0 returns its synchronised pad level.
- R6: The direction register is at byte address 0x400. Bit n = 1 makes pin n an output (`pad_oe[n]` = 1). Bit n = 0 makes it an input. A read at 0x400 returns the register.
- R7: A data write to a pin that is an input still updates its output bit on `pad_out`. After the direction bit is set, the pin drives that stored value.
- R8: A pad level change becomes visible in data reads exactly two rising clock edges after it is applied. After one edge, reads still show the old level.
- R9: Writes to unaligned addresses (bits [1:0] nonzero), to addresses 0x404 through 0xFFF, or with `bus_sel` low change no state. Reads at those addresses, or with `bus_sel` low, return 0.
- R10: A write takes effect at the rising edge on which it is presented. `bus_rdata` is combinational from the address and the current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for this block |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |

## Verification
Read data is due in the same cycle as the address, so the bench samples it 1 ns after it drives the address, on the falling clock edge. Register writes are due one rising edge after they are presented, so `pad_oe` and `pad_out` are checked at the following falling edge, and a check taken before that edge confirms that nothing has changed yet. Pad inputs are due two rising edges after they change. The vector loop therefore idles two edges before every read-back, and one directed test reads the pins after the first edge and again after the second to pin down that latency.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;

    localparam int PIN_COUNT    = 8;
    localparam int BUS_ADDR_W   = 12;
    localparam int DIR_BYTE_OFF = 'h400;
    localparam int SYNC_DEPTH   = 2;

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_DATA = 2'd1,
        REGION_DIR  = 2'd2
    } region_e;

    function automatic region_e classify(input logic aligned,
                                         input logic in_window,
                                         input logic at_dir);
        if (!aligned)       return REGION_NONE;
        else if (in_window) return REGION_DATA;
        else if (at_dir)    return REGION_DIR;
        else                return REGION_NONE;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= '0;
            else if (s == 0)
                stage_q[s] <= raw;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
        end
    end

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mw_pkg::*;
#(
    parameter int PINS       = 8,
    parameter int ADDR_W     = 12,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [PINS-1:0]   mask
);
    localparam int MASK_LSB = 2;
    localparam int MASK_MSB = MASK_LSB + PINS - 1;
    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

    logic aligned, in_window, at_dir;

    assign aligned   = (addr[MASK_LSB-1:0] == '0);
    assign in_window = (addr[ADDR_W-1:MASK_MSB+1] == '0);
    assign at_dir    = (addr[ADDR_W-1:MASK_LSB] == DIR_ADDR[ADDR_W-1:MASK_LSB]);
    assign mask      = addr[MASK_MSB:MASK_LSB];
    assign region    = classify(aligned, in_window, at_dir);
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            data_wr,
    input  logic            dir_wr,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] dir_q
);
    for (genvar n = 0; n < PINS; n++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                out_q[n] <= 1'b0;
            else if (data_wr && mask[n])
                out_q[n] <= wdata[n];
        end

        always_ff @(posedge clk) begin
            if (rst)
                dir_q[n] <= 1'b0;
            else if (dir_wr)
                dir_q[n] <= wdata[n];
        end
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mw_pkg::*;
#(
    parameter int PINS       = gpio_mw_pkg::PIN_COUNT,
    parameter int ADDR_W     = gpio_mw_pkg::BUS_ADDR_W,
    parameter int DIR_OFFSET = gpio_mw_pkg::DIR_BYTE_OFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);
    region_e         region;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] out_q, dir_q, pin_sync, pin_view;
    logic            wr_strobe;

    gpio_addr_decode #(
        .PINS(PINS), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)
    ) u_decode (
        .addr   (bus_addr),
        .region (region),
        .mask   (mask)
    );

    assign wr_strobe = bus_sel && bus_we;

    gpio_pin_regs #(.PINS(PINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .data_wr (wr_strobe && (region == REGION_DATA)),
        .dir_wr  (wr_strobe && (region == REGION_DIR)),
        .mask    (mask),
        .wdata   (bus_wdata),
        .out_q   (out_q),
        .dir_q   (dir_q)
    );

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pad_in),
        .synced (pin_sync)
    );

    // Output pins reflect what is driven; input pins reflect the pad.
    assign pin_view = (dir_q & out_q) | (~dir_q & pin_sync);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (region)
                REGION_DATA: bus_rdata = pin_view & mask;
                REGION_DIR:  bus_rdata = dir_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign pad_oe  = dir_q;
    assign pad_out = out_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int PINS       = 8,
    parameter int ADDR_W     = 12,
    parameter int DIR_OFFSET = 'h400
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out
);
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFFSET);

    logic [PINS-1:0] sel_mask;
    logic            aligned, win, dir_hit, wr;
    logic            seen_edge, rst_prev;

    assign sel_mask = bus_addr[PINS+1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign win      = aligned && (bus_addr[ADDR_W-1:PINS+2] == '0);
    assign dir_hit  = aligned && (bus_addr[ADDR_W-1:2] == DIR_A[ADDR_W-1:2]);
    assign wr       = bus_sel && bus_we;

    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_prev  <= rst;
    end

    // R1: one edge into reset, nothing is driven
    always @(posedge clk) begin
        if (seen_edge === 1'b1 && rst_prev === 1'b1)
            a_r1_reset_idle: assert (pad_oe == '0 && pad_out == '0);
    end

    a_r2_masked_write: assert property (@(posedge clk) disable iff (rst)
        (wr && win) |=> ((pad_out & $past(sel_mask)) == ($past(bus_wdata) & $past(sel_mask))));

    a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        (wr && win) |=> ((pad_out & ~$past(sel_mask)) == ($past(pad_out) & ~$past(sel_mask))));

    a_r4_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && win) |-> ((bus_rdata & ~sel_mask) == '0));

    a_r5_output_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && win) |-> ((bus_rdata & sel_mask & pad_oe) == (pad_out & sel_mask & pad_oe)));

    a_r6_dir_write: assert property (@(posedge clk) disable iff (rst)
        (wr && dir_hit) |=> (pad_oe == $past(bus_wdata)));

    a_r9_ignored_write: assert property (@(posedge clk) disable iff (rst)
        (!(wr && (win || dir_hit))) |=> ($stable(pad_oe) && $stable(pad_out)));

    a_r9_idle_read: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel) |-> (bus_rdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .PINS(PINS), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_mask_port dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  pad;
        logic [11:0] chk;
        logic [7:0]  rd;
        logic [7:0]  oe;
        logic [7:0]  out;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h400, 8'h0F, 8'hA5, 12'h3FC, 8'hA0, 8'h0F, 8'h00},
        '{1'b1, 12'h3FC, 8'h3C, 8'hA5, 12'h3FC, 8'hAC, 8'h0F, 8'h3C},
        '{1'b1, 12'h004, 8'hFF, 8'hA5, 12'h004, 8'h01, 8'h0F, 8'h3D},
        '{1'b1, 12'h080, 8'h00, 8'hA5, 12'h080, 8'h20, 8'h0F, 8'h1D},
        '{1'b1, 12'h204, 8'h7E, 8'hA5, 12'h204, 8'h80, 8'h0F, 8'h1C},
        '{1'b1, 12'h404, 8'hFF, 8'h5A, 12'h3FC, 8'h5C, 8'h0F, 8'h1C},
        '{1'b1, 12'hFFC, 8'h00, 8'h5A, 12'h400, 8'h0F, 8'h0F, 8'h1C},
        '{1'b1, 12'h400, 8'hF0, 8'h5A, 12'h3FC, 8'h1A, 8'hF0, 8'h1C},
        '{1'b1, 12'h3C0, 8'hFF, 8'h00, 12'h3FC, 8'hF0, 8'hF0, 8'hFC},
        '{1'b0, 12'h000, 8'h00, 8'h0F, 12'h03C, 8'h0F, 8'hF0, 8'hFC},
        '{1'b1, 12'h001, 8'h00, 8'h0F, 12'h3FC, 8'hFF, 8'hF0, 8'hFC}
    };

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R6";
            1:       return "R2";
            2:       return "R4";
            3:       return "R7";
            4:       return "R3";
            5, 6:    return "R9";
            7:       return "R5";
            8:       return "R3";
            9:       return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check("R1", "oe in reset", pad_oe, 8'h00);
        check("R1", "out in reset", pad_out, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        bus_read(12'h400, rd); check("R1", "dir after reset", rd, 8'h00);
        bus_read(12'h3FC, rd); check("R1", "pins after reset", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            pad_in = VEC[i].pad;
            if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].wdata);
            @(negedge clk);
            @(negedge clk);
            bus_read(VEC[i].chk, rd);
            check(tag_of(i), $sformatf("vec %0d rdata", i), rd, VEC[i].rd);
            check(tag_of(i), $sformatf("vec %0d oe", i), pad_oe, VEC[i].oe);
            check(tag_of(i), $sformatf("vec %0d out", i), pad_out, VEC[i].out);
        end

        // R9: write with bus_sel low changes nothing, idle read is zero
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 12'h400; bus_wdata = 8'h00;
        #1 check("R9", "idle rdata", bus_rdata, 8'h00);
        @(negedge clk);
        bus_we = 1'b0;
        check("R9", "oe after unselected write", pad_oe, 8'hF0);

        // R10: write lands at the edge, not before
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h400; bus_wdata = 8'hFF;
        #1 check("R10", "oe before edge", pad_oe, 8'hF0);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        check("R10", "oe after edge", pad_oe, 8'hFF);
        bus_write(12'h400, 8'h00);

        // R8: two-edge input latency
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hFF;
        @(negedge clk);
        bus_read(12'h3FC, rd); check("R8", "pins after one edge", rd, 8'h00);
        @(negedge clk);
        bus_read(12'h3FC, rd); check("R8", "pins after two edges", rd, 8'hFF);

        // R7: preload while input, then drive
        bus_write(12'h008, 8'h00);
        check("R7", "out preloaded", pad_out, 8'hFC);
        bus_write(12'h400, 8'h02);
        bus_read(12'h008, rd); check("R7", "driven pin reads stored 0", rd, 8'h00);

        // R1: reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1", "oe after late reset", pad_oe, 8'h00);
        check("R1", "out after late reset", pad_out, 8'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule